// File: doc/BRIEF.md
# Top-Relative Register Stack

This block holds eight wide entries, each 80 bits by default, for a stack-style numeric unit. Software addresses the entries relative to a rotating top pointer: ST(0) is the entry the pointer names, and ST(i) is the entry i places below it. A push or a pop moves the pointer and so changes the numbering of every entry. No data moves. A valid tag on each entry records whether it holds a value.

On each clock the block takes one operation code. The operations are: reset the stack, push a value, read the top with or without removing it, swap the top with ST(i), and write a result into ST(i) with an optional pop. A two-operand write-back always uses ST(0) as one operand. It checks that ST(0) and ST(i) both hold values before it writes. Two combinational read ports return the contents and the tag of any relative index. Two sticky flags record a push onto an occupied slot (overflow) and an operation that uses an empty slot (underflow). An operation that faults changes nothing except its flag.

Top module: `tos_regfile`

## Requirements
- R1: Reset, and op code 1 (init), set the top pointer to 0, mark all entries empty and clear both flags.
- R2: Op code 2 (push) decrements the top pointer by one modulo 8, writes op_data into the new ST(0) and marks it valid. The old ST(i) then reads as ST(i+1).
- R3: When the slot below the top is already valid, a push sets the sticky overflow flag and leaves the pointer, tags and contents unchanged.
- R4: Op code 3 (store) leaves the pointer, tags and contents unchanged. ST(0) stays readable.
- R5: Op code 4 (store-pop) marks ST(0) empty and increments the pointer, so the old ST(i) reads as ST(i-1).
- R6: Op code 5 (exchange) swaps the contents of ST(0) and ST(op_idx).
- R7: Op code 6 (write) stores op_data into ST(op_idx) and leaves the pointer unchanged.
- R8: Op code 7 (write-pop) stores op_data into ST(op_idx) and then pops, so the value reads as ST(op_idx-1).
- R9: Ops 3 and 4 with an empty ST(0), and ops 5 to 7 with ST(0) or ST(op_idx) empty, set the sticky underflow flag and change no other state.
- R10: Once set, each flag stays set until reset or init. Op code 0 is a no-operation.
- R11: The read ports are combinational. A read in the same cycle as a write to the same entry returns the old value.
- R12: Each read port reports the valid tag of the entry it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Operation selector, applied at the clock edge |
| op_idx | input | 3 | Relative index i for exchange and write |
| op_data | input | 80 | Value for push and write |
| rd_idx_a | input | 3 | Relative index for read port A |
| rd_data_a | output | 80 | Contents of ST(rd_idx_a) |
| rd_valid_a | output | 1 | Tag of ST(rd_idx_a) |
| rd_idx_b | input | 3 | Relative index for read port B |
| rd_data_b | output | 80 | Contents of ST(rd_idx_b) |
| rd_valid_b | output | 1 | Tag of ST(rd_idx_b) |
| tos_ptr | output | 3 | Physical index of ST(0) |
| stk_overflow | output | 1 | Sticky push-onto-occupied flag |
| stk_underflow | output | 1 | Sticky empty-operand flag |

## Verification
A scripted sequence of pushes, an exchange, a plain write, a store, a write-pop and a pop exercises the main function. It then reads different relative depths, so a wrong pointer direction or a wrong offset sum gives a different value than the correct rotation would. Filling all eight slots and pushing a ninth time separates correct overflow suppression from a write that overwrites the oldest entry. Operations on empty slots show that underflow freezes the pointer and the contents. A read taken before and after a write edge separates old-value reads from write-through.

// File: rtl/tos_pkg.sv
package tos_pkg;
   typedef enum logic [2:0] {
      TOS_NOP       = 3'd0,
      TOS_INIT      = 3'd1,
      TOS_PUSH      = 3'd2,
      TOS_STORE     = 3'd3,
      TOS_STORE_POP = 3'd4,
      TOS_XCHG      = 3'd5,
      TOS_WRITE     = 3'd6,
      TOS_WRITE_POP = 3'd7
   } tos_op_e;
endpackage

// File: rtl/tos_tag_bank.sv
module tos_tag_bank #(
   parameter int IDX_W = 3,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_addr,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_addr,
   output logic [DEPTH-1:0] tag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
         tag_q <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (set_en && set_addr == IDX_W'(e))      tag_q[e] <= 1'b1;
            else if (clr_en && clr_addr == IDX_W'(e)) tag_q[e] <= 1'b0;
         end
      end
   end

   a_r1_tags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (tag_q == '0));
endmodule

// File: rtl/tos_entry_array.sv
module tos_entry_array #(
   parameter int DATA_W = 80,
   parameter int IDX_W  = 3,
   parameter int N_RD   = 4,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr0_en,
   input  logic [IDX_W-1:0]  wr0_addr,
   input  logic [DATA_W-1:0] wr0_data,
   input  logic              wr1_en,
   input  logic [IDX_W-1:0]  wr1_addr,
   input  logic [DATA_W-1:0] wr1_data,
   input  logic [IDX_W-1:0]  rd_addr [N_RD],
   output logic [DATA_W-1:0] rd_data [N_RD]
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (wr1_en && wr1_addr == IDX_W'(e))      mem[e] <= wr1_data;
         else if (wr0_en && wr0_addr == IDX_W'(e)) mem[e] <= wr0_data;
      end
   end

   for (genvar p = 0; p < N_RD; p++) begin : g_rd
      assign rd_data[p] = mem[rd_addr[p]];
   end

   // R7: a lone write lands in the addressed entry on the next cycle
   a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0_en && !(wr1_en && wr1_addr == wr0_addr))
         |=> (mem[$past(wr0_addr)] == $past(wr0_data)));
endmodule

// File: rtl/tos_ctrl.sv
module tos_ctrl
   import tos_pkg::*;
#(
   parameter int IDX_W = 3,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tos_op_e          op,
   input  logic [IDX_W-1:0] idx,
   input  logic [DEPTH-1:0] tag_vec,
   output logic [IDX_W-1:0] top_q,
   output logic [IDX_W-1:0] sel_addr,
   output logic             ovf_q,
   output logic             unf_q,
   output logic             wr0_en,
   output logic [IDX_W-1:0] wr0_addr,
   output logic             wr0_swap,
   output logic             wr1_en,
   output logic [IDX_W-1:0] wr1_addr,
   output logic             tag_set_en,
   output logic [IDX_W-1:0] tag_set_addr,
   output logic             tag_clr_en,
   output logic [IDX_W-1:0] tag_clr_addr,
   output logic             tag_clr_all
);
   logic [IDX_W-1:0] top_d, push_slot;
   logic             top_ok, sel_ok, ovf_set, unf_set;

   assign sel_addr  = top_q + idx;
   assign push_slot = top_q - 1'b1;
   assign top_ok    = tag_vec[top_q];
   assign sel_ok    = tag_vec[sel_addr];

   always_comb begin
      top_d = top_q;       ovf_set = 1'b0;     unf_set = 1'b0;
      wr0_en = 1'b0;       wr0_addr = top_q;   wr0_swap = 1'b0;
      wr1_en = 1'b0;       wr1_addr = sel_addr;
      tag_set_en = 1'b0;   tag_set_addr = push_slot;
      tag_clr_en = 1'b0;   tag_clr_addr = top_q;
      tag_clr_all = 1'b0;
      unique case (op)
         TOS_INIT: begin
            tag_clr_all = 1'b1;
            top_d       = '0;
         end
         TOS_PUSH: begin
            if (tag_vec[push_slot]) ovf_set = 1'b1;
            else begin
               wr0_en = 1'b1;  wr0_addr = push_slot;
               tag_set_en = 1'b1;
               top_d = push_slot;
            end
         end
         TOS_STORE: unf_set = !top_ok;
         TOS_STORE_POP: begin
            if (!top_ok) unf_set = 1'b1;
            else begin
               tag_clr_en = 1'b1;
               top_d = top_q + 1'b1;
            end
         end
         TOS_XCHG: begin
            if (!(top_ok && sel_ok)) unf_set = 1'b1;
            else begin
               wr0_en = 1'b1;  wr0_swap = 1'b1;
               wr1_en = 1'b1;
            end
         end
         TOS_WRITE, TOS_WRITE_POP: begin
            if (!(top_ok && sel_ok)) unf_set = 1'b1;
            else begin
               wr0_en = 1'b1;  wr0_addr = sel_addr;
               if (op == TOS_WRITE_POP) begin
                  tag_clr_en = 1'b1;
                  top_d = top_q + 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || op == TOS_INIT) begin
         top_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         top_q <= top_d;
         ovf_q <= ovf_q | ovf_set;
         unf_q <= unf_q | unf_set;
      end
   end

   a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (op == TOS_INIT) |=> (top_q == '0 && !ovf_q && !unf_q));
   a_r2_push_lowers_top: assert property (@(posedge clk) disable iff (!rst_n)
      (op == TOS_PUSH && !tag_vec[top_q - 1'b1])
         |=> (top_q == IDX_W'($past(top_q) - 1'b1)) && tag_vec[top_q]);
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (op == TOS_PUSH && tag_vec[top_q - 1'b1])
         |=> (ovf_q && top_q == $past(top_q) && tag_vec == $past(tag_vec)));
   a_r5_pop_frees_top: assert property (@(posedge clk) disable iff (!rst_n)
      (op == TOS_STORE_POP && tag_vec[top_q])
         |=> (top_q == IDX_W'($past(top_q) + 1'b1)) && !tag_vec[$past(top_q)]);
   a_r9_underflow_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      unf_set |=> (unf_q && top_q == $past(top_q) && tag_vec == $past(tag_vec)));
   a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovf_q || unf_q) && op != TOS_INIT)
         |=> ((ovf_q || !$past(ovf_q)) && (unf_q || !$past(unf_q))));
endmodule

// File: rtl/tos_regfile.sv
module tos_regfile
   import tos_pkg::*;
#(
   parameter int DATA_W = 80,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_code,
   input  logic [IDX_W-1:0]  op_idx,
   input  logic [DATA_W-1:0] op_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   output logic              rd_valid_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b,
   output logic              rd_valid_b,
   output logic [IDX_W-1:0]  tos_ptr,
   output logic              stk_overflow,
   output logic              stk_underflow
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int N_RD  = 4;

   if (DATA_W < 1) begin : g_bad_width
      $error("tos_regfile: DATA_W must be at least 1");
   end
   if (IDX_W < 1 || IDX_W > 6) begin : g_bad_depth
      $error("tos_regfile: IDX_W must be between 1 and 6");
   end

   tos_op_e           op;
   logic [DEPTH-1:0]  tag_q;
   logic [IDX_W-1:0]  top_q, sel_addr, wr0_addr, wr1_addr;
   logic [IDX_W-1:0]  tag_set_addr, tag_clr_addr;
   logic              wr0_en, wr0_swap, wr1_en;
   logic              tag_set_en, tag_clr_en, tag_clr_all;
   logic [DATA_W-1:0] wr0_data;
   logic [IDX_W-1:0]  rd_addr [N_RD];
   logic [DATA_W-1:0] rd_data [N_RD];

   assign op = tos_op_e'(op_code);

   tos_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk, .rst_n, .op, .idx(op_idx), .tag_vec(tag_q),
      .top_q, .sel_addr, .ovf_q(stk_overflow), .unf_q(stk_underflow),
      .wr0_en, .wr0_addr, .wr0_swap, .wr1_en, .wr1_addr,
      .tag_set_en, .tag_set_addr, .tag_clr_en, .tag_clr_addr, .tag_clr_all
   );

   tos_tag_bank #(.IDX_W(IDX_W)) u_tags (
      .clk, .rst_n, .clr_all(tag_clr_all),
      .set_en(tag_set_en), .set_addr(tag_set_addr),
      .clr_en(tag_clr_en), .clr_addr(tag_clr_addr),
      .tag_q
   );

   // ports 0/1 face the outside, 2 feeds the swap from ST(i), 3 the swap from ST(0)
   assign rd_addr[0] = top_q + rd_idx_a;
   assign rd_addr[1] = top_q + rd_idx_b;
   assign rd_addr[2] = sel_addr;
   assign rd_addr[3] = top_q;

   assign wr0_data = wr0_swap ? rd_data[2] : op_data;

   tos_entry_array #(.DATA_W(DATA_W), .IDX_W(IDX_W), .N_RD(N_RD)) u_array (
      .clk, .rst_n,
      .wr0_en, .wr0_addr, .wr0_data,
      .wr1_en, .wr1_addr, .wr1_data(rd_data[3]),
      .rd_addr, .rd_data
   );

   assign rd_data_a  = rd_data[0];
   assign rd_data_b  = rd_data[1];
   assign rd_valid_a = tag_q[rd_addr[0]];
   assign rd_valid_b = tag_q[rd_addr[1]];
   assign tos_ptr    = top_q;

   // R6: an exchange leaves both involved entries occupied
   a_r6_swap_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0_swap && wr1_en) |=> (tag_q[$past(wr1_addr)] && tag_q[$past(wr0_addr)]));
endmodule

// File: tb/tb_tos_regfile.sv
module tb_tos_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic [2:0]  op_idx = 3'd0;
   logic [79:0] op_data = '0;
   logic [2:0]  rd_idx_a = 3'd0, rd_idx_b = 3'd0;
   logic [79:0] rd_data_a, rd_data_b;
   logic        rd_valid_a, rd_valid_b;
   logic [2:0]  tos_ptr;
   logic        stk_overflow, stk_underflow;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   tos_regfile dut (
      .clk, .rst_n, .op_code, .op_idx, .op_data,
      .rd_idx_a, .rd_data_a, .rd_valid_a,
      .rd_idx_b, .rd_data_b, .rd_valid_b,
      .tos_ptr, .stk_overflow, .stk_underflow
   );

   typedef struct packed {
      logic [2:0]  op;
      logic [2:0]  idx;
      logic [79:0] din;
      logic [2:0]  ridx;
      logic [79:0] exp;
      logic        ev;
      logic        cd;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{3'd1, 3'd0, 80'd0,  3'd0, 80'd0,  1'b0, 1'b0},  // R1 init, top empty
      '{3'd2, 3'd0, 80'd10, 3'd0, 80'd10, 1'b1, 1'b1},  // R2 push
      '{3'd2, 3'd0, 80'd20, 3'd1, 80'd10, 1'b1, 1'b1},  // R2 old top now ST(1)
      '{3'd2, 3'd0, 80'd30, 3'd0, 80'd30, 1'b1, 1'b1},  // R2
      '{3'd5, 3'd2, 80'd0,  3'd0, 80'd10, 1'b1, 1'b1},  // R6 exchange with ST(2)
      '{3'd0, 3'd0, 80'd0,  3'd2, 80'd30, 1'b1, 1'b1},  // R6 other side
      '{3'd6, 3'd1, 80'd55, 3'd1, 80'd55, 1'b1, 1'b1},  // R7 write ST(1)
      '{3'd3, 3'd0, 80'd0,  3'd0, 80'd10, 1'b1, 1'b1},  // R4 store keeps top
      '{3'd7, 3'd2, 80'd77, 3'd1, 80'd77, 1'b1, 1'b1},  // R8 write-pop ST(2)
      '{3'd4, 3'd0, 80'd0,  3'd0, 80'd77, 1'b1, 1'b1},  // R5 pop
      '{3'd0, 3'd0, 80'd0,  3'd1, 80'd0,  1'b0, 1'b0}   // R5 R12 ST(1) empty
   };

   task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] din);
      op_code = op; op_idx = idx; op_data = din;
      @(posedge clk);
      #1;
      op_code = 3'd0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 reset tos_ptr", 80'(tos_ptr), 80'd0);
      chk("R1 reset overflow", 80'(stk_overflow), 80'd0);
      chk("R1 reset underflow", 80'(stk_underflow), 80'd0);
      chk("R1 reset ST0 empty", 80'(rd_valid_a), 80'd0);

      for (int k = 0; k < NV; k++) begin
         run(VECS[k].op, VECS[k].idx, VECS[k].din);
         rd_idx_a = VECS[k].ridx;
         #1;
         chk($sformatf("vector %0d R12 valid", k), 80'(rd_valid_a), 80'(VECS[k].ev));
         if (VECS[k].cd) chk($sformatf("vector %0d data", k), rd_data_a, VECS[k].exp);
      end
      chk("R9 vectors raise no underflow", 80'(stk_underflow), 80'd0);

      // R2 pointer wraps below zero
      run(3'd1, 3'd0, 80'd0);
      run(3'd2, 3'd0, 80'd5);
      chk("R2 top wraps to 7", 80'(tos_ptr), 80'd7);
      // R4 store leaves pointer and tag
      run(3'd3, 3'd0, 80'd0);
      rd_idx_a = 3'd0; #1;
      chk("R4 store keeps pointer", 80'(tos_ptr), 80'd7);
      chk("R4 store keeps tag", 80'(rd_valid_a), 80'd1);

      // R3 overflow after eight pushes
      run(3'd1, 3'd0, 80'd0);
      for (int k = 0; k < 8; k++) run(3'd2, 3'd0, 80'(100 + k));
      chk("R3 full stack no overflow yet", 80'(stk_overflow), 80'd0);
      run(3'd2, 3'd0, 80'd999);
      rd_idx_a = 3'd0; rd_idx_b = 3'd7; #1;
      chk("R3 overflow flag", 80'(stk_overflow), 80'd1);
      chk("R3 top contents kept", rd_data_a, 80'd107);
      chk("R3 pointer kept", 80'(tos_ptr), 80'd0);
      chk("R12 port b deepest entry", rd_data_b, 80'd100);
      chk("R12 port b valid", 80'(rd_valid_b), 80'd1);
      run(3'd0, 3'd0, 80'd0);
      chk("R10 overflow sticky over nop", 80'(stk_overflow), 80'd1);
      run(3'd4, 3'd0, 80'd0);
      rd_idx_a = 3'd0; #1;
      chk("R5 pop exposes next", rd_data_a, 80'd106);
      chk("R10 overflow sticky over pop", 80'(stk_overflow), 80'd1);
      run(3'd1, 3'd0, 80'd0);
      chk("R1 init clears overflow", 80'(stk_overflow), 80'd0);

      // R9 underflow cases
      run(3'd4, 3'd0, 80'd0);
      chk("R9 pop empty sets underflow", 80'(stk_underflow), 80'd1);
      chk("R9 pop empty keeps pointer", 80'(tos_ptr), 80'd0);
      run(3'd1, 3'd0, 80'd0);
      run(3'd2, 3'd0, 80'd42);
      run(3'd5, 3'd3, 80'd0);
      rd_idx_a = 3'd0; #1;
      chk("R9 swap with empty sets underflow", 80'(stk_underflow), 80'd1);
      chk("R9 swap with empty keeps top", rd_data_a, 80'd42);
      run(3'd6, 3'd2, 80'd88);
      rd_idx_a = 3'd0; #1;
      chk("R9 write to empty keeps top", rd_data_a, 80'd42);
      chk("R9 write to empty keeps pointer", 80'(tos_ptr), 80'd7);

      // R11 same-cycle read returns old value
      op_code = 3'd6; op_idx = 3'd0; op_data = 80'd2; rd_idx_a = 3'd0;
      #1;
      chk("R11 read before edge old", rd_data_a, 80'd42);
      @(posedge clk); #1; op_code = 3'd0; #1;
      chk("R11 read after edge new", rd_data_a, 80'd2);

      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule